// File: doc/BRIEF.md
# Microcoded Step Sequencer with Interrupt Swap

This block is the control sequencer of a small microcoded 8-bit processor. It holds the opcode being executed and a 3-bit micro-step counter, and presents both to an external decode ROM. In return it takes the ROM's control lines: the next-step bits and their load strobe, four flag-conditional lines, and the fetch, jump, prefetch, prefetch-use, pointer-advance and vector-load strobes. It also owns the instruction pointer `ip`, the interrupt vector register `vec` and the run, interrupt and interrupt-request flags. Memory reads for opcode fetch are combinational: the sequencer drives `mem_addr` and `mem_rd`, and the byte on `mem_rdata` is captured at the next clock edge. `ip` always holds the address of the opcode currently in the opcode register.

Seven control opcodes act on the sequencer's own state and are executed by it directly, ignoring the ROM lines: clear (0x00), halt (0xF0), run (0xF1), interrupt entry (0xF2), software break (0xF3), interrupt return (0xF4) and no-op (0xFF). Interrupt entry, break and return swap `ip` with `vec` and fetch at the old `vec` in a single cycle. A pending hardware request is taken only at an instruction boundary, which is a fetch or a prefetch-use. At that point the sequencer advances `ip` to the boundary target and forces opcode 0xF2 instead of reading memory, so the entry saves the address of the first instruction that has not run.

The state machine has three states. BOOT fetches at `ip` without any boundary test and always moves to EXEC. EXEC either executes a control opcode or follows the ROM lines. From EXEC, a clear opcode returns to BOOT, and a boundary with the run flag clear and no interrupt active moves to HALT. HALT holds until the request flag is set, then moves to EXEC with opcode 0xF2 forced.

Top module: `mseq_core`

## Requirements
- R1: Reset puts the block in BOOT with `ip`=0, `vec`=0, run flag 1, interrupt and request flags 0 and `op_valid`=0. BOOT reads address `ip` (`mem_rd`=1), loads that byte as opcode with step 0, leaves `ip` unchanged and enters EXEC.
- R2: In EXEC with a non-control opcode, `rom_ld_sub`=1 loads the step with `rom_nstep` OR-ed in bit 0 with the condition result. With `rom_ld_sub`=0 the step holds.
- R3: The condition result is the OR of four terms: `rom_cnz` with `zf`=0, `rom_cz` with `zf`=1, `rom_cnc` with `cf`=0 and `rom_cc` with `cf`=1.
- R4: `rom_fetch` is a boundary whose target is `jmp_addr` when `rom_jump`=1 and `ip`+1 otherwise. A normal boundary reads the target, loads the opcode, sets `ip` to the target and clears the step.
- R5: `rom_pre` reads `ip`+1 into a prefetch register and advances `ip` by one, while step loading still applies. `rom_use_pre` is a boundary with target `ip` that moves the prefetch register into the opcode without a memory read and clears the step. Priority is fetch, then prefetch-use, then the other strobes.
- R6: `rom_ip_inc` advances `ip` by one without changing the opcode. `rom_vec_ld` loads `vec` from `jmp_addr`.
- R7: Opcode 0x00 asserts `clear_all` for one cycle. It sets `ip` and `vec` to 0, sets the run flag, clears the interrupt and request flags and returns to BOOT.
- R8: Opcode 0xF0 clears the run flag, 0xF1 sets it and 0xFF changes no flag. Each then takes a boundary with target `ip`+1, and 0xF0 applies the new run value to that boundary.
- R9: Opcodes 0xF2, 0xF3 and 0xF4 read address `vec`, load that byte as opcode and set `ip` to the old `vec`. 0xF2 saves the old `ip` into `vec`, while 0xF3 and 0xF4 save the old `ip`+1.
- R10: 0xF2 and 0xF3 set the interrupt flag and 0xF4 clears it. 0xF2 also clears the request flag. An `irq_req` pulse sets the request flag, and a pulse in the same cycle as a clear by 0xF2 is kept.
- R11: A boundary with the run flag clear and no interrupt active sets `ip` to the target and enters HALT without a read. In HALT `ip` is stable, `mem_rd`=0, `op_valid`=0 and the step is 0. In HALT a set request flag forces opcode 0xF2 and moves to EXEC.
- R12: A pending request with the interrupt flag clear is taken only at a boundary: `ip` takes the target, opcode 0xF2 is forced and no read is made. While the interrupt flag is set, boundaries fetch normally and the request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_rdata | input | 8 | Byte read at `mem_addr` |
| mem_addr | output | AW | Opcode read address |
| mem_rd | output | 1 | Opcode or prefetch read in this cycle |
| jmp_addr | input | AW | Jump target and vector load value from the address unit |
| zf | input | 1 | Zero flag |
| cf | input | 1 | Carry flag |
| rom_nstep | input | SW | Next-step bits from the ROM |
| rom_ld_sub | input | 1 | Load the step from `rom_nstep` |
| rom_cnz | input | 1 | Condition: zero clear |
| rom_cz | input | 1 | Condition: zero set |
| rom_cnc | input | 1 | Condition: carry clear |
| rom_cc | input | 1 | Condition: carry set |
| rom_fetch | input | 1 | End of instruction, fetch next |
| rom_jump | input | 1 | Fetch target is `jmp_addr` |
| rom_pre | input | 1 | Prefetch the next opcode |
| rom_use_pre | input | 1 | Move the prefetched opcode in |
| rom_ip_inc | input | 1 | Advance `ip` past an immediate byte |
| rom_vec_ld | input | 1 | Load `vec` from `jmp_addr` |
| irq_req | input | 1 | Interrupt request pulse |
| op_code | output | 8 | Current opcode |
| op_step | output | SW | Current micro-step |
| op_valid | output | 1 | In EXEC: ROM outputs are used |
| halted | output | 1 | In HALT |
| ip_out | output | AW | Instruction pointer |
| clear_all | output | 1 | Clear opcode executing this cycle |
| run_flag | output | 1 | Run flag |
| int_flag | output | 1 | Interrupt active flag |
| irq_flag | output | 1 | Request pending flag |

## Verification
Every register result (opcode, step, `ip`, `vec`, the flags and the state) is due at the first rising edge after the cycle whose inputs cause it. `mem_addr`, `mem_rd` and `clear_all` are combinational in that same cycle. A control opcode loaded at one edge acts in the following cycle, so its effects land one edge later again. The bench drives inputs just after a falling edge and checks the combinational outputs before the next rising edge. It checks the registered results at the falling edge after that rising edge, walking a fixed program one edge at a time through each chain of fetch, swap, halt and forced entry. The step logic is swept over every value of the next-step bits, the four condition lines and both flags.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_EXEC = 2'd1,
        ST_HALT = 2'd2
    } seq_state_t;

    localparam logic [7:0] OPC_CLEAR = 8'h00;
    localparam logic [7:0] OPC_HALT  = 8'hF0;
    localparam logic [7:0] OPC_RUN   = 8'hF1;
    localparam logic [7:0] OPC_IENT  = 8'hF2;
    localparam logic [7:0] OPC_BRK   = 8'hF3;
    localparam logic [7:0] OPC_IRET  = 8'hF4;
    localparam logic [7:0] OPC_NOP   = 8'hFF;

    // Number of flag-conditional lines and the flag level each one wants.
    localparam int unsigned NCOND = 4;
    // bit0: zero clear, bit1: zero set, bit2: carry clear, bit3: carry set
    localparam logic [NCOND-1:0] COND_WANT = 4'b1010;

    function automatic logic is_ctrl_op(input logic [7:0] op);
        return (op == OPC_CLEAR) || (op == OPC_HALT) || (op == OPC_RUN) ||
               (op == OPC_IENT)  || (op == OPC_BRK)  || (op == OPC_IRET) ||
               (op == OPC_NOP);
    endfunction

endpackage

// File: rtl/mseq_step.sv
module mseq_step #(
    parameter int unsigned SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ld,
    input  logic [SW-1:0] nstep,
    input  logic [mseq_pkg::NCOND-1:0] cond_en,
    input  logic          zf,
    input  logic          cf,
    output logic [SW-1:0] step
);
    import mseq_pkg::*;

    logic [NCOND-1:0] flag_sel;
    logic [NCOND-1:0] hit;
    logic             take;

    assign flag_sel = {cf, cf, zf, zf};

    for (genvar k = 0; k < NCOND; k++) begin : g_cond
        assign hit[k] = cond_en[k] & (flag_sel[k] == COND_WANT[k]);
    end

    assign take = |hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step <= '0;
        end else if (clr) begin
            step <= '0;
        end else if (ld) begin
            step <= nstep | {{(SW-1){1'b0}}, take};
        end
    end

endmodule

// File: rtl/mseq_ptr.sv
module mseq_ptr #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ip_we,
    input  logic [AW-1:0] ip_d,
    input  logic          vec_we,
    input  logic [AW-1:0] vec_d,
    output logic [AW-1:0] ip_q,
    output logic [AW-1:0] vec_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ip_q  <= '0;
            vec_q <= '0;
        end else if (clr) begin
            ip_q  <= '0;
            vec_q <= '0;
        end else begin
            if (ip_we)  ip_q  <= ip_d;
            if (vec_we) vec_q <= vec_d;
        end
    end

endmodule

// File: rtl/mseq_flags.sv
module mseq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run_we,
    input  logic run_d,
    input  logic int_we,
    input  logic int_d,
    input  logic irq_clr,
    input  logic irq_req,
    output logic run_q,
    output logic int_q,
    output logic irq_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b1;
            int_q <= 1'b0;
            irq_q <= 1'b0;
        end else if (clr) begin
            run_q <= 1'b1;
            int_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            if (run_we) run_q <= run_d;
            if (int_we) int_q <= int_d;
            irq_q <= (irq_q & ~irq_clr) | irq_req;
        end
    end

endmodule

// File: rtl/mseq_core.sv
module mseq_core #(
    parameter int unsigned AW = 16,
    parameter int unsigned SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    input  logic [AW-1:0] jmp_addr,
    input  logic          zf,
    input  logic          cf,
    input  logic [SW-1:0] rom_nstep,
    input  logic          rom_ld_sub,
    input  logic          rom_cnz,
    input  logic          rom_cz,
    input  logic          rom_cnc,
    input  logic          rom_cc,
    input  logic          rom_fetch,
    input  logic          rom_jump,
    input  logic          rom_pre,
    input  logic          rom_use_pre,
    input  logic          rom_ip_inc,
    input  logic          rom_vec_ld,
    input  logic          irq_req,
    output logic [7:0]    op_code,
    output logic [SW-1:0] op_step,
    output logic          op_valid,
    output logic          halted,
    output logic [AW-1:0] ip_out,
    output logic          clear_all,
    output logic          run_flag,
    output logic          int_flag,
    output logic          irq_flag
);
    import mseq_pkg::*;

    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    seq_state_t state_q, state_nx;

    logic [7:0]    op_q, pre_q, op_d;
    logic          op_we, pre_we;
    logic [AW-1:0] ip_q, vec_q, ip_d, vec_d, ip_nxt;
    logic          ip_we, vec_we;
    logic          step_clr, step_ld;
    logic          run_q, int_q, irq_q;
    logic          run_we, run_d, int_we, int_d, irq_clr, clr_c;
    logic          rd_c;
    logic [AW-1:0] addr_c;
    logic          bnd, bnd_mem, run_eff;
    logic [AW-1:0] bnd_tgt;

    assign ip_nxt = ip_q + ONE;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            op_q    <= OPC_CLEAR;
            pre_q   <= '0;
        end else begin
            state_q <= state_nx;
            if (op_we)  op_q  <= op_d;
            if (pre_we) pre_q <= mem_rdata;
        end
    end

    // next state and control outputs
    always_comb begin
        state_nx = state_q;
        rd_c     = 1'b0;
        addr_c   = ip_nxt;
        op_we    = 1'b0;
        op_d     = mem_rdata;
        pre_we   = 1'b0;
        step_clr = 1'b0;
        step_ld  = 1'b0;
        ip_we    = 1'b0;
        ip_d     = ip_nxt;
        vec_we   = 1'b0;
        vec_d    = jmp_addr;
        run_we   = 1'b0;
        run_d    = 1'b0;
        int_we   = 1'b0;
        int_d    = 1'b0;
        irq_clr  = 1'b0;
        clr_c    = 1'b0;
        bnd      = 1'b0;
        bnd_mem  = 1'b1;
        bnd_tgt  = ip_nxt;

        unique case (state_q)
            ST_BOOT: begin
                rd_c     = 1'b1;
                addr_c   = ip_q;
                op_we    = 1'b1;
                step_clr = 1'b1;
                state_nx = ST_EXEC;
            end
            ST_HALT: begin
                if (irq_q) begin
                    op_we    = 1'b1;
                    op_d     = OPC_IENT;
                    step_clr = 1'b1;
                    state_nx = ST_EXEC;
                end
            end
            ST_EXEC: begin
                if (is_ctrl_op(op_q)) begin
                    unique case (op_q)
                        OPC_CLEAR: begin
                            clr_c    = 1'b1;
                            step_clr = 1'b1;
                            state_nx = ST_BOOT;
                        end
                        OPC_HALT: begin
                            run_we = 1'b1;
                            run_d  = 1'b0;
                            bnd    = 1'b1;
                        end
                        OPC_RUN: begin
                            run_we = 1'b1;
                            run_d  = 1'b1;
                            bnd    = 1'b1;
                        end
                        OPC_IENT, OPC_BRK, OPC_IRET: begin
                            rd_c     = 1'b1;
                            addr_c   = vec_q;
                            op_we    = 1'b1;
                            step_clr = 1'b1;
                            ip_we    = 1'b1;
                            ip_d     = vec_q;
                            vec_we   = 1'b1;
                            vec_d    = (op_q == OPC_IENT) ? ip_q : ip_nxt;
                            int_we   = 1'b1;
                            int_d    = (op_q != OPC_IRET);
                            irq_clr  = (op_q == OPC_IENT);
                        end
                        default: begin
                            bnd = 1'b1;
                        end
                    endcase
                end else begin
                    if (rom_vec_ld) begin
                        vec_we = 1'b1;
                        vec_d  = jmp_addr;
                    end
                    if (rom_fetch) begin
                        bnd     = 1'b1;
                        bnd_tgt = rom_jump ? jmp_addr : ip_nxt;
                    end else if (rom_use_pre) begin
                        bnd     = 1'b1;
                        bnd_mem = 1'b0;
                        bnd_tgt = ip_q;
                    end else begin
                        step_ld = rom_ld_sub;
                        if (rom_pre) begin
                            rd_c   = 1'b1;
                            addr_c = ip_nxt;
                            pre_we = 1'b1;
                            ip_we  = 1'b1;
                        end else if (rom_ip_inc) begin
                            ip_we = 1'b1;
                        end
                    end
                end
            end
            default: state_nx = ST_BOOT;
        endcase

        // instruction boundary: forced entry, halt or normal load
        if (bnd) begin
            ip_we    = 1'b1;
            ip_d     = bnd_tgt;
            step_clr = 1'b1;
            if (irq_q && !int_q) begin
                op_we = 1'b1;
                op_d  = OPC_IENT;
            end else if (!run_eff && !int_q) begin
                state_nx = ST_HALT;
            end else begin
                op_we = 1'b1;
                if (bnd_mem) begin
                    rd_c   = 1'b1;
                    addr_c = bnd_tgt;
                    op_d   = mem_rdata;
                end else begin
                    op_d = pre_q;
                end
            end
        end
    end

    assign run_eff = run_we ? run_d : run_q;

    mseq_step #(.SW(SW)) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (step_clr),
        .ld      (step_ld),
        .nstep   (rom_nstep),
        .cond_en ({rom_cc, rom_cnc, rom_cz, rom_cnz}),
        .zf      (zf),
        .cf      (cf),
        .step    (op_step)
    );

    mseq_ptr #(.AW(AW)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_c),
        .ip_we  (ip_we),
        .ip_d   (ip_d),
        .vec_we (vec_we),
        .vec_d  (vec_d),
        .ip_q   (ip_q),
        .vec_q  (vec_q)
    );

    mseq_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_c),
        .run_we  (run_we),
        .run_d   (run_d),
        .int_we  (int_we),
        .int_d   (int_d),
        .irq_clr (irq_clr),
        .irq_req (irq_req),
        .run_q   (run_q),
        .int_q   (int_q),
        .irq_q   (irq_q)
    );

    assign mem_addr  = addr_c;
    assign mem_rd    = rd_c;
    assign op_code   = op_q;
    assign op_valid  = (state_q == ST_EXEC);
    assign halted    = (state_q == ST_HALT);
    assign ip_out    = ip_q;
    assign clear_all = clr_c;
    assign run_flag  = run_q;
    assign int_flag  = int_q;
    assign irq_flag  = irq_q;

endmodule

// File: rtl/mseq_core_chk.sv
module mseq_core_chk #(
    parameter int unsigned AW = 16,
    parameter int unsigned SW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd,
    input logic          halted,
    input logic          op_valid,
    input logic [7:0]    op_code,
    input logic [SW-1:0] op_step,
    input logic [AW-1:0] ip_out,
    input logic          clear_all,
    input logic          run_flag,
    input logic          int_flag,
    input logic          irq_flag
);

    // R11
    halt_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !op_valid && op_step == '0));

    // R11
    halt_ip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !irq_flag) |=> $stable(ip_out));

    // R7
    clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (ip_out == '0 && run_flag && !int_flag && !irq_flag && !op_valid));

    // R10
    int_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_flag) |-> ($past(op_code) == 8'hF2 || $past(op_code) == 8'hF3));

    // R10
    int_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_flag) |-> ($past(op_code) == 8'hF4 || $past(op_code) == 8'h00));

    // R9
    entry_sets_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 8'hF2) |=> int_flag);

endmodule

bind mseq_core mseq_core_chk #(.AW(AW), .SW(SW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .halted    (halted),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_step   (op_step),
    .ip_out    (ip_out),
    .clear_all (clear_all),
    .run_flag  (run_flag),
    .int_flag  (int_flag),
    .irq_flag  (irq_flag)
);

// File: tb/mseq_core_tb.sv
`timescale 1ns/1ps
module mseq_core_tb;

    localparam int unsigned AW = 16;
    localparam int unsigned SW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [7:0]    mem_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_rd;
    logic [AW-1:0] jmp_addr;
    logic          zf, cf;
    logic [SW-1:0] rom_nstep;
    logic          rom_ld_sub, rom_cnz, rom_cz, rom_cnc, rom_cc;
    logic          rom_fetch, rom_jump, rom_pre, rom_use_pre, rom_ip_inc, rom_vec_ld;
    logic          irq_req;
    logic [7:0]    op_code;
    logic [SW-1:0] op_step;
    logic          op_valid, halted, clear_all, run_flag, int_flag, irq_flag;
    logic [AW-1:0] ip_out;

    logic [7:0] mem [0:255];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];

    mseq_core #(.AW(AW), .SW(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .jmp_addr(jmp_addr), .zf(zf), .cf(cf),
        .rom_nstep(rom_nstep), .rom_ld_sub(rom_ld_sub), .rom_cnz(rom_cnz),
        .rom_cz(rom_cz), .rom_cnc(rom_cnc), .rom_cc(rom_cc),
        .rom_fetch(rom_fetch), .rom_jump(rom_jump), .rom_pre(rom_pre),
        .rom_use_pre(rom_use_pre), .rom_ip_inc(rom_ip_inc), .rom_vec_ld(rom_vec_ld),
        .irq_req(irq_req), .op_code(op_code), .op_step(op_step),
        .op_valid(op_valid), .halted(halted), .ip_out(ip_out),
        .clear_all(clear_all), .run_flag(run_flag), .int_flag(int_flag),
        .irq_flag(irq_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        rom_ld_sub = 0; rom_fetch = 0; rom_jump = 0; rom_pre = 0;
        rom_use_pre = 0; rom_ip_inc = 0; rom_vec_ld = 0; irq_req = 0;
        rom_cnz = 0; rom_cz = 0; rom_cnc = 0; rom_cc = 0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 8'h30;
        mem[8'h00] = 8'h10; mem[8'h01] = 8'h11; mem[8'h20] = 8'h12; mem[8'h21] = 8'h13;
        mem[8'h23] = 8'hFF; mem[8'h24] = 8'hF1; mem[8'h25] = 8'hF3; mem[8'h26] = 8'hF0;
        mem[8'h27] = 8'h15; mem[8'h80] = 8'h14; mem[8'h81] = 8'hF4; mem[8'h82] = 8'hF1;
        mem[8'h83] = 8'hF4; mem[8'h84] = 8'h16; mem[8'h85] = 8'h00;

        rst_n = 0; jmp_addr = '0; zf = 0; cf = 0; rom_nstep = '0;
        quiet();
        repeat (3) cyc();
        rst_n = 1;
        #1;
        // R1 reset state and boot read
        chk("R1 op_valid", op_valid, 0);
        chk("R1 mem_rd", mem_rd, 1);
        chk("R1 mem_addr", mem_addr, 0);
        chk("R1 run", run_flag, 1);
        chk("R1 int", int_flag, 0);
        chk("R1 irq", irq_flag, 0);
        chk("R1 ip", ip_out, 0);
        cyc();
        chk("R1 boot opcode", op_code, 8'h10);
        chk("R1 boot step", op_step, 0);
        chk("R1 boot ip", ip_out, 0);
        chk("R1 boot valid", op_valid, 1);

        // R2 R3 sweep of next-step bits, conditions and flags
        for (int n = 0; n < 8; n++) begin
            for (int c = 0; c < 16; c++) begin
                for (int z = 0; z < 2; z++) begin
                    for (int f = 0; f < 2; f++) begin
                        logic cb;
                        rom_nstep = n[SW-1:0];
                        rom_cnz = c[0]; rom_cz = c[1]; rom_cnc = c[2]; rom_cc = c[3];
                        zf = z[0]; cf = f[0]; rom_ld_sub = 1;
                        cb = (c[0] & ~z[0]) | (c[1] & z[0]) | (c[2] & ~f[0]) | (c[3] & f[0]);
                        cyc();
                        chk("R3 cond step", op_step, n[SW-1:0] | {2'b00, cb});
                    end
                end
            end
        end
        quiet();
        rom_nstep = 3'd0;
        cyc();
        chk("R2 step holds", op_step, 3'd7);
        chk("R2 opcode holds", op_code, 8'h10);

        // R6 vector load
        rom_vec_ld = 1; jmp_addr = 16'h0080;
        cyc();
        quiet();
        // R4 plain fetch
        rom_fetch = 1;
        #1 chk("R4 fetch addr", mem_addr, 16'h0001);
        cyc();
        chk("R4 fetch opcode", op_code, 8'h11);
        chk("R4 fetch ip", ip_out, 16'h0001);
        chk("R4 fetch step", op_step, 0);
        // R4 jump fetch
        rom_jump = 1; jmp_addr = 16'h0020;
        cyc();
        chk("R4 jump opcode", op_code, 8'h12);
        chk("R4 jump ip", ip_out, 16'h0020);
        quiet();
        // R5 prefetch with step load
        rom_pre = 1; rom_ld_sub = 1; rom_nstep = 3'd5;
        cyc();
        chk("R5 prefetch opcode kept", op_code, 8'h12);
        chk("R5 prefetch ip", ip_out, 16'h0021);
        chk("R5 prefetch step", op_step, 3'd5);
        quiet();
        rom_use_pre = 1;
        #1 chk("R5 use_pre no read", mem_rd, 0);
        cyc();
        chk("R5 use_pre opcode", op_code, 8'h13);
        chk("R5 use_pre ip", ip_out, 16'h0021);
        chk("R5 use_pre step", op_step, 0);
        quiet();
        // R6 pointer advance
        rom_ip_inc = 1;
        cyc();
        chk("R6 ip_inc ip", ip_out, 16'h0022);
        chk("R6 ip_inc opcode", op_code, 8'h13);
        quiet();
        rom_fetch = 1;
        cyc();
        quiet();
        chk("R4 fetch nop", op_code, 8'hFF);
        // R8 nop then run opcode
        cyc();
        chk("R8 nop ip", ip_out, 16'h0024);
        chk("R8 nop next", op_code, 8'hF1);
        cyc();
        chk("R8 run flag", run_flag, 1);
        chk("R8 run next", op_code, 8'hF3);
        // R9 software break
        #1 chk("R9 brk reads vec", mem_addr, 16'h0080);
        cyc();
        chk("R9 brk ip", ip_out, 16'h0080);
        chk("R9 brk opcode", op_code, 8'h14);
        chk("R10 brk int", int_flag, 1);
        rom_fetch = 1;
        cyc();
        quiet();
        chk("R4 handler fetch", op_code, 8'hF4);
        // R9 return
        cyc();
        chk("R9 ret ip", ip_out, 16'h0026);
        chk("R9 ret opcode", op_code, 8'hF0);
        chk("R10 ret int", int_flag, 0);
        // R8 halt opcode, R11 hold
        cyc();
        chk("R8 halt run", run_flag, 0);
        chk("R11 halted", halted, 1);
        chk("R11 halt ip", ip_out, 16'h0027);
        chk("R11 halt no read", mem_rd, 0);
        repeat (3) cyc();
        chk("R11 halt ip hold", ip_out, 16'h0027);
        chk("R11 still halted", halted, 1);
        chk("R11 halt invalid", op_valid, 0);
        // R11 wake by request
        irq_req = 1;
        cyc();
        irq_req = 0;
        chk("R10 irq set", irq_flag, 1);
        chk("R11 halted before wake", halted, 1);
        cyc();
        chk("R11 forced entry", op_code, 8'hF2);
        chk("R11 wake ip", ip_out, 16'h0027);
        chk("R11 wake valid", op_valid, 1);
        #1 chk("R9 entry reads vec", mem_addr, 16'h0082);
        cyc();
        chk("R9 entry ip", ip_out, 16'h0082);
        chk("R10 entry int", int_flag, 1);
        chk("R10 entry irq clear", irq_flag, 0);
        chk("R9 entry opcode", op_code, 8'hF1);
        cyc();
        chk("R8 run in handler", run_flag, 1);
        chk("R8 run fetch", op_code, 8'hF4);
        cyc();
        chk("R9 entry saved ip", ip_out, 16'h0027);
        chk("R9 resume opcode", op_code, 8'h15);
        chk("R10 resume int", int_flag, 0);
        // R12 request waits for a boundary
        irq_req = 1;
        cyc();
        irq_req = 0;
        cyc();
        chk("R12 no entry before boundary", op_code, 8'h15);
        chk("R12 ip unchanged", ip_out, 16'h0027);
        chk("R12 pending", irq_flag, 1);
        rom_fetch = 1;
        #1 chk("R12 entry no read", mem_rd, 0);
        cyc();
        quiet();
        chk("R12 forced opcode", op_code, 8'hF2);
        chk("R12 boundary ip", ip_out, 16'h0028);
        cyc();
        chk("R9 second entry ip", ip_out, 16'h0084);
        chk("R9 second entry opcode", op_code, 8'h16);
        // R12 masked while interrupt active
        irq_req = 1;
        cyc();
        irq_req = 0;
        rom_fetch = 1;
        #1 chk("R12 masked read", mem_rd, 1);
        cyc();
        quiet();
        chk("R12 masked fetch", op_code, 8'h00);
        chk("R12 masked ip", ip_out, 16'h0085);
        chk("R12 still pending", irq_flag, 1);
        // R7 clear opcode
        #1 chk("R7 clear pulse", clear_all, 1);
        cyc();
        chk("R7 ip", ip_out, 0);
        chk("R7 int", int_flag, 0);
        chk("R7 irq", irq_flag, 0);
        chk("R7 run", run_flag, 1);
        chk("R7 boot state", op_valid, 0);
        cyc();
        chk("R7 refetch", op_code, 8'h10);
        chk("R7 refetch ip", ip_out, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule